// File: doc/BRIEF.md
# Randomized Turn-Count Path Selector for a Square Mesh

This block chooses an oblivious route for a packet entering a K x K mesh and then steers that packet one hop at a time. When the packet is injected, the selector takes the source coordinates, a mode bit and a random word, and it produces a route header. The header holds a path class, a waypoint and a two-bit leg counter. In one-turn mode the packet goes either X-then-Y or Y-then-X, and each order has an even chance. Both orders are minimal. In two-turn mode the selector picks one of 2K candidates with equal weight. A candidate is either a waypoint column in the source row (class XYX) or a waypoint row in the source column (class YXY). The packet first travels along one dimension to the waypoint. It then routes minimally to the destination in the opposite dimension order. Because the waypoint can lie outside the span between source and destination, a two-turn path may be longer than minimal.

At each router, the hop stage takes the current node, the destination and the header fields. From these it computes the output port and the updated leg counter. Both results appear on registered outputs one cycle later. The header stage and the hop stage work independently of each other, and each is qualified by its own valid bit. Flow control and channel assignment for deadlock freedom are handled elsewhere.

Top module: `turn_path_router`

## Requirements
- R1: While reset is high, and on the first cycle after it, `hdr_valid` and `out_valid` are low.
- R2: In one-turn mode (`inj_two_turn`=0), bit 0 of `inj_rand` selects the class: 0 gives XY (code 0) and 1 gives YX (code 1). The waypoint equals the source and the leg is 1.
- R3: In two-turn mode the index is `inj_rand` mod 2K. An index below K gives XYX (code 2) with waypoint (index, source y). Any other index gives YXY (code 3) with waypoint (source x, index-K).
- R4: In two-turn mode the header leg is 1 when the waypoint equals the source, and 0 otherwise.
- R5: With leg 0 and the current node not at the waypoint, the hop port moves toward the waypoint along X for XYX, or along Y for YXY, and the output leg stays 0. A node equal to the waypoint is treated as having finished leg 0.
- R6: After the waypoint, classes XY and YXY resolve X before Y, and classes YX and XYX resolve Y before X. A move in the first-resolved dimension gives output leg 1, and a move in the second gives output leg 2.
- R7: The local port is chosen only when the current node equals the destination and leg 0 is finished. A packet with leg 0 that sits at its destination but not at its waypoint still moves on.
- R8: Port codes are: 0 local, 1 east (x+1), 2 west (x-1), 3 north (y+1), 4 south (y-1).
- R9: Each output set updates on the clock edge after its valid input is high, and holds its value while that valid input is low.
- R10: On a local decision the output leg is the finished leg (1 if the input leg was 0, otherwise the input leg).
- R11: Following the hop ports from any injected header reaches the destination. A one-turn path has at most 1 turn and exactly |dx|+|dy| hops. A two-turn path has at most 2 turns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | 1 | Injection request valid |
| inj_src_x | input | CW | Source column |
| inj_src_y | input | CW | Source row |
| inj_two_turn | input | 1 | 1 selects two-turn mode |
| inj_rand | input | RW | Random word for path choice |
| hdr_valid | output | 1 | Header outputs valid |
| hdr_class | output | 2 | Path class (0 XY, 1 YX, 2 XYX, 3 YXY) |
| hdr_wp_x | output | CW | Waypoint column |
| hdr_wp_y | output | CW | Waypoint row |
| hdr_leg | output | 2 | Initial leg counter |
| hop_valid | input | 1 | Hop request valid |
| hop_cur_x | input | CW | Current node column |
| hop_cur_y | input | CW | Current node row |
| hop_dst_x | input | CW | Destination column |
| hop_dst_y | input | CW | Destination row |
| hop_class | input | 2 | Path class from header |
| hop_wp_x | input | CW | Waypoint column from header |
| hop_wp_y | input | CW | Waypoint row from header |
| hop_leg | input | 2 | Current leg counter |
| out_valid | output | 1 | Hop decision valid |
| out_port | output | 3 | Output port code |
| out_leg | output | 2 | Updated leg counter |

## Verification
The bench builds the block with K=5 and RW=16. An odd radix means the index range 2K=10 is not a power of two, so the modulo reduction is actually exercised. The coordinate field is three bits wide with unused codes above 4. Five columns also leave room for waypoints well outside the source–destination span, which makes non-minimal detours and waypoints that coincide with the source or destination easy to reach. Random words larger than 2K exercise the wrap of the index. The bench follows every generated path to its end and counts hops and turns.

// File: rtl/turn_route_pkg.sv
package turn_route_pkg;

    localparam int MAXCW = 8;

    typedef enum logic [1:0] {
        PC_XY  = 2'd0,
        PC_YX  = 2'd1,
        PC_XYX = 2'd2,
        PC_YXY = 2'd3
    } path_class_e;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    typedef struct packed {
        port_e      port;
        logic [1:0] leg;
    } hop_dec_t;

    // Direction along X from cur toward tgt
    function automatic port_e step_x(input logic [MAXCW-1:0] cur, input logic [MAXCW-1:0] tgt);
        if (cur < tgt)      return PORT_EAST;
        else if (cur > tgt) return PORT_WEST;
        else                return PORT_LOCAL;
    endfunction

    // Direction along Y from cur toward tgt
    function automatic port_e step_y(input logic [MAXCW-1:0] cur, input logic [MAXCW-1:0] tgt);
        if (cur < tgt)      return PORT_NORTH;
        else if (cur > tgt) return PORT_SOUTH;
        else                return PORT_LOCAL;
    endfunction

    function automatic logic is_one_turn(input path_class_e c);
        return (c == PC_XY) || (c == PC_YX);
    endfunction

    // Final stage resolves X before Y
    function automatic logic final_x_first(input path_class_e c);
        return (c == PC_XY) || (c == PC_YXY);
    endfunction

endpackage

// File: rtl/path_pick.sv
module path_pick
    import turn_route_pkg::*;
#(
    parameter int K  = 4,
    parameter int CW = 2,
    parameter int RW = 16
) (
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic          two_turn,
    input  logic [RW-1:0] rnd,
    output path_class_e   cls,
    output logic [CW-1:0] wp_x,
    output logic [CW-1:0] wp_y,
    output logic [1:0]    leg
);
    localparam int NCAND = 2 * K;

    logic [RW-1:0] idx;

    always_comb begin
        idx  = rnd % RW'(NCAND);
        cls  = PC_XY;
        wp_x = src_x;
        wp_y = src_y;
        leg  = 2'd1;
        if (!two_turn) begin
            cls = rnd[0] ? PC_YX : PC_XY;
        end else if (idx < RW'(K)) begin
            cls  = PC_XYX;
            wp_x = CW'(idx);
        end else begin
            cls  = PC_YXY;
            wp_y = CW'(idx - RW'(K));
        end
        if (two_turn) begin
            leg = ((wp_x == src_x) && (wp_y == src_y)) ? 2'd1 : 2'd0;
        end
    end

endmodule

// File: rtl/hop_port.sv
module hop_port
    import turn_route_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] wp_x,
    input  logic [CW-1:0] wp_y,
    input  path_class_e   cls,
    input  logic [1:0]    leg,
    output hop_dec_t      dec
);
    port_e      to_wx, to_wy, to_dx, to_dy;
    logic       past_wp;
    logic [1:0] done_leg;

    always_comb begin
        to_wx    = step_x(MAXCW'(cur_x), MAXCW'(wp_x));
        to_wy    = step_y(MAXCW'(cur_y), MAXCW'(wp_y));
        to_dx    = step_x(MAXCW'(cur_x), MAXCW'(dst_x));
        to_dy    = step_y(MAXCW'(cur_y), MAXCW'(dst_y));
        past_wp  = is_one_turn(cls) || (leg != 2'd0) ||
                   ((cur_x == wp_x) && (cur_y == wp_y));
        done_leg = (leg == 2'd0) ? 2'd1 : leg;

        if (!past_wp) begin
            dec.port = (cls == PC_XYX) ? to_wx : to_wy;
            dec.leg  = 2'd0;
        end else if (final_x_first(cls)) begin
            if (to_dx != PORT_LOCAL) begin
                dec.port = to_dx;
                dec.leg  = 2'd1;
            end else if (to_dy != PORT_LOCAL) begin
                dec.port = to_dy;
                dec.leg  = 2'd2;
            end else begin
                dec.port = PORT_LOCAL;
                dec.leg  = done_leg;
            end
        end else begin
            if (to_dy != PORT_LOCAL) begin
                dec.port = to_dy;
                dec.leg  = 2'd1;
            end else if (to_dx != PORT_LOCAL) begin
                dec.port = to_dx;
                dec.leg  = 2'd2;
            end else begin
                dec.port = PORT_LOCAL;
                dec.leg  = done_leg;
            end
        end
    end

endmodule

// File: rtl/turn_path_router.sv
module turn_path_router
    import turn_route_pkg::*;
#(
    parameter int K  = 4,
    parameter int CW = (K > 1) ? $clog2(K) : 1,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inj_valid,
    input  logic [CW-1:0] inj_src_x,
    input  logic [CW-1:0] inj_src_y,
    input  logic          inj_two_turn,
    input  logic [RW-1:0] inj_rand,
    output logic          hdr_valid,
    output logic [1:0]    hdr_class,
    output logic [CW-1:0] hdr_wp_x,
    output logic [CW-1:0] hdr_wp_y,
    output logic [1:0]    hdr_leg,
    input  logic          hop_valid,
    input  logic [CW-1:0] hop_cur_x,
    input  logic [CW-1:0] hop_cur_y,
    input  logic [CW-1:0] hop_dst_x,
    input  logic [CW-1:0] hop_dst_y,
    input  logic [1:0]    hop_class,
    input  logic [CW-1:0] hop_wp_x,
    input  logic [CW-1:0] hop_wp_y,
    input  logic [1:0]    hop_leg,
    output logic          out_valid,
    output logic [2:0]    out_port,
    output logic [1:0]    out_leg
);
    path_class_e   pick_cls;
    logic [CW-1:0] pick_wp_x, pick_wp_y;
    logic [1:0]    pick_leg;
    hop_dec_t      hop_dec;

    path_pick #(.K(K), .CW(CW), .RW(RW)) u_pick (
        .src_x    (inj_src_x),
        .src_y    (inj_src_y),
        .two_turn (inj_two_turn),
        .rnd      (inj_rand),
        .cls      (pick_cls),
        .wp_x     (pick_wp_x),
        .wp_y     (pick_wp_y),
        .leg      (pick_leg)
    );

    hop_port #(.CW(CW)) u_hop (
        .cur_x (hop_cur_x),
        .cur_y (hop_cur_y),
        .dst_x (hop_dst_x),
        .dst_y (hop_dst_y),
        .wp_x  (hop_wp_x),
        .wp_y  (hop_wp_y),
        .cls   (path_class_e'(hop_class)),
        .leg   (hop_leg),
        .dec   (hop_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_valid <= 1'b0;
            hdr_class <= '0;
            hdr_wp_x  <= '0;
            hdr_wp_y  <= '0;
            hdr_leg   <= '0;
            out_valid <= 1'b0;
            out_port  <= '0;
            out_leg   <= '0;
        end else begin
            hdr_valid <= inj_valid;
            if (inj_valid) begin
                hdr_class <= pick_cls;
                hdr_wp_x  <= pick_wp_x;
                hdr_wp_y  <= pick_wp_y;
                hdr_leg   <= pick_leg;
            end
            out_valid <= hop_valid;
            if (hop_valid) begin
                out_port <= hop_dec.port;
                out_leg  <= hop_dec.leg;
            end
        end
    end

endmodule

// File: rtl/turn_path_router_chk.sv
module turn_path_router_chk #(
    parameter int K  = 4,
    parameter int CW = 2,
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          inj_valid,
    input logic [CW-1:0] inj_src_x,
    input logic [CW-1:0] inj_src_y,
    input logic          inj_two_turn,
    input logic [RW-1:0] inj_rand,
    input logic          hdr_valid,
    input logic [1:0]    hdr_class,
    input logic [CW-1:0] hdr_wp_x,
    input logic [CW-1:0] hdr_wp_y,
    input logic [1:0]    hdr_leg,
    input logic          hop_valid,
    input logic [CW-1:0] hop_cur_x,
    input logic [CW-1:0] hop_cur_y,
    input logic [CW-1:0] hop_dst_x,
    input logic [CW-1:0] hop_dst_y,
    input logic [1:0]    hop_class,
    input logic [CW-1:0] hop_wp_x,
    input logic [CW-1:0] hop_wp_y,
    input logic [1:0]    hop_leg,
    input logic          out_valid,
    input logic [2:0]    out_port,
    input logic [1:0]    out_leg
);
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (hdr_valid == $past(inj_valid)) && (out_valid == $past(hop_valid)));

    p_hdr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(inj_valid)) |->
            $stable(hdr_class) && $stable(hdr_wp_x) && $stable(hdr_wp_y) && $stable(hdr_leg));

    p_port_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hop_valid)) |-> $stable(out_port) && $stable(out_leg));

    p_one_turn_hdr_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hdr_valid && !$past(inj_two_turn)) |->
            (hdr_class[1] == 1'b0) && (hdr_wp_x == $past(inj_src_x)) &&
            (hdr_wp_y == $past(inj_src_y)) && (hdr_leg == 2'd1));

    p_two_turn_wp_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hdr_valid && $past(inj_two_turn)) |->
            hdr_class[1] && (int'(hdr_wp_x) < K) && (int'(hdr_wp_y) < K) &&
            (hdr_class[0] ? (hdr_wp_x == $past(inj_src_x)) : (hdr_wp_y == $past(inj_src_y))));

    p_skip_leg_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hdr_valid && $past(inj_two_turn)) |->
            ((hdr_leg == 2'd0) == ((hdr_wp_x != $past(inj_src_x)) || (hdr_wp_y != $past(inj_src_y)))));

    // R7: local only at the destination once the waypoint leg is over
    p_local_at_dest_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && (out_port == 3'd0)) |->
            ($past(hop_cur_x) == $past(hop_dst_x)) && ($past(hop_cur_y) == $past(hop_dst_y)) &&
            (($past(hop_leg) != 2'd0) || !$past(hop_class[1]) ||
             (($past(hop_cur_x) == $past(hop_wp_x)) && ($past(hop_cur_y) == $past(hop_wp_y)))));

    p_port_range_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_port <= 3'd4));

    // R5: leg stays 0 only while still heading for the waypoint
    p_leg_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && (out_leg == 2'd0)) |->
            ($past(hop_leg) == 2'd0) && (out_port != 3'd0));

    always_comb begin
        if (!rst) begin
            a_reset_clean_r1: assert (!$isunknown({hdr_valid, out_valid}));
        end
    end

endmodule

bind turn_path_router turn_path_router_chk #(.K(K), .CW(CW), .RW(RW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .inj_valid    (inj_valid),
    .inj_src_x    (inj_src_x),
    .inj_src_y    (inj_src_y),
    .inj_two_turn (inj_two_turn),
    .inj_rand     (inj_rand),
    .hdr_valid    (hdr_valid),
    .hdr_class    (hdr_class),
    .hdr_wp_x     (hdr_wp_x),
    .hdr_wp_y     (hdr_wp_y),
    .hdr_leg      (hdr_leg),
    .hop_valid    (hop_valid),
    .hop_cur_x    (hop_cur_x),
    .hop_cur_y    (hop_cur_y),
    .hop_dst_x    (hop_dst_x),
    .hop_dst_y    (hop_dst_y),
    .hop_class    (hop_class),
    .hop_wp_x     (hop_wp_x),
    .hop_wp_y     (hop_wp_y),
    .hop_leg      (hop_leg),
    .out_valid    (out_valid),
    .out_port     (out_port),
    .out_leg      (out_leg)
);

// File: tb/sim_turn_path_router.sv
module sim_turn_path_router;
    localparam int CLK_PERIOD = 10;
    localparam int BK  = 5;
    localparam int BCW = 3;
    localparam int BRW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           inj_valid = 1'b0;
    logic [BCW-1:0] inj_src_x = '0, inj_src_y = '0;
    logic           inj_two_turn = 1'b0;
    logic [BRW-1:0] inj_rand = '0;
    logic           hdr_valid;
    logic [1:0]     hdr_class;
    logic [BCW-1:0] hdr_wp_x, hdr_wp_y;
    logic [1:0]     hdr_leg;
    logic           hop_valid = 1'b0;
    logic [BCW-1:0] hop_cur_x = '0, hop_cur_y = '0, hop_dst_x = '0, hop_dst_y = '0;
    logic [1:0]     hop_class = '0;
    logic [BCW-1:0] hop_wp_x = '0, hop_wp_y = '0;
    logic [1:0]     hop_leg = '0;
    logic           out_valid;
    logic [2:0]     out_port;
    logic [1:0]     out_leg;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    turn_path_router #(.K(BK), .CW(BCW), .RW(BRW)) u0 (
        .clk(clk), .rst(rst),
        .inj_valid(inj_valid), .inj_src_x(inj_src_x), .inj_src_y(inj_src_y),
        .inj_two_turn(inj_two_turn), .inj_rand(inj_rand),
        .hdr_valid(hdr_valid), .hdr_class(hdr_class), .hdr_wp_x(hdr_wp_x),
        .hdr_wp_y(hdr_wp_y), .hdr_leg(hdr_leg),
        .hop_valid(hop_valid), .hop_cur_x(hop_cur_x), .hop_cur_y(hop_cur_y),
        .hop_dst_x(hop_dst_x), .hop_dst_y(hop_dst_y), .hop_class(hop_class),
        .hop_wp_x(hop_wp_x), .hop_wp_y(hop_wp_y), .hop_leg(hop_leg),
        .out_valid(out_valid), .out_port(out_port), .out_leg(out_leg)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_hdr(input int sx, input int sy, input bit two, input int rnd,
                                      output int cls, output int wx, output int wy, output int leg);
        int idx;
        idx = rnd % (2 * BK);
        wx = sx; wy = sy; leg = 1;
        if (!two) cls = rnd % 2;
        else if (idx < BK) begin cls = 2; wx = idx; end
        else begin cls = 3; wy = idx - BK; end
        if (two) leg = (wx == sx && wy == sy) ? 1 : 0;
    endfunction

    function automatic int xdir(input int c, input int t);
        return (c < t) ? 1 : (c > t) ? 2 : 0;
    endfunction

    function automatic int ydir(input int c, input int t);
        return (c < t) ? 3 : (c > t) ? 4 : 0;
    endfunction

    function automatic void model_hop(input int cx, input int cy, input int dx, input int dy,
                                      input int wx, input int wy, input int cls, input int leg,
                                      output int port, output int nleg, output string req);
        bit done;
        int first, second;
        done = (cls < 2) || (leg != 0) || (cx == wx && cy == wy);
        if (!done) begin
            port = (cls == 2) ? xdir(cx, wx) : ydir(cy, wy);
            nleg = 0;
            req = "R5";
            return;
        end
        if (cls == 0 || cls == 3) begin first = xdir(cx, dx); second = ydir(cy, dy); end
        else begin first = ydir(cy, dy); second = xdir(cx, dx); end
        if (first != 0) begin port = first; nleg = 1; req = "R6"; end
        else if (second != 0) begin port = second; nleg = 2; req = "R6"; end
        else begin port = 0; nleg = (leg == 0) ? 1 : leg; req = "R7"; end
    endfunction

    task automatic walk(input int sx, input int sy, input int dx, input int dy, input bit two, input int rnd);
        int ecls, ewx, ewy, eleg;
        int cx, cy, leg, hops, turns, lastdim, dim, eport, enleg, p;
        bit reached;
        string req;
        model_hdr(sx, sy, two, rnd, ecls, ewx, ewy, eleg);
        @(negedge clk);
        inj_valid = 1'b1; inj_src_x = BCW'(sx); inj_src_y = BCW'(sy);
        inj_two_turn = two; inj_rand = BRW'(rnd);
        @(negedge clk);
        inj_valid = 1'b0;
        chk(hdr_valid == 1'b1, "R9", "hdr_valid", int'(hdr_valid), 1);
        chk(int'(hdr_class) == ecls, two ? "R3" : "R2", "class", int'(hdr_class), ecls);
        chk(int'(hdr_wp_x) == ewx && int'(hdr_wp_y) == ewy, two ? "R3" : "R2", "waypoint x*8+y",
            int'(hdr_wp_x) * 8 + int'(hdr_wp_y), ewx * 8 + ewy);
        chk(int'(hdr_leg) == eleg, "R4", "header leg", int'(hdr_leg), eleg);
        cx = sx; cy = sy; leg = int'(hdr_leg); hops = 0; turns = 0; lastdim = -1; reached = 0;
        for (int h = 0; h < 4 * BK + 2; h++) begin
            model_hop(cx, cy, dx, dy, int'(hdr_wp_x), int'(hdr_wp_y), int'(hdr_class), leg, eport, enleg, req);
            hop_valid = 1'b1; hop_cur_x = BCW'(cx); hop_cur_y = BCW'(cy);
            hop_dst_x = BCW'(dx); hop_dst_y = BCW'(dy); hop_class = hdr_class;
            hop_wp_x = hdr_wp_x; hop_wp_y = hdr_wp_y; hop_leg = 2'(leg);
            @(negedge clk);
            hop_valid = 1'b0;
            p = int'(out_port);
            chk(p == eport, req, "port", p, eport);
            chk(int'(out_leg) == enleg, "R10", "out leg", int'(out_leg), enleg);
            if (p == 0) begin reached = 1; break; end
            // R8: port codes decoded as moves
            case (p)
                1: cx = cx + 1;
                2: cx = cx - 1;
                3: cy = cy + 1;
                default: cy = cy - 1;
            endcase
            dim = (p <= 2) ? 0 : 1;
            if (lastdim >= 0 && dim != lastdim) turns++;
            lastdim = dim;
            hops++;
            leg = int'(out_leg);
        end
        chk(reached && cx == dx && cy == dy, "R11", "reached dest x*8+y", cx * 8 + cy, dx * 8 + dy);
        chk(turns <= (two ? 2 : 1), "R11", "turns", turns, two ? 2 : 1);
        if (!two) begin
            int mh;
            mh = (dx > sx ? dx - sx : sx - dx) + (dy > sy ? dy - sy : sy - dy);
            chk(hops == mh, "R11", "one-turn hop count", hops, mh);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [BCW-1:0] held_x, held_y;
        logic [2:0]     held_port;
        void'($urandom(32'd20240611));
        @(negedge clk);
        inj_valid = 1'b1; hop_valid = 1'b1;
        @(negedge clk);
        chk(hdr_valid == 1'b0 && out_valid == 1'b0, "R1", "valids in reset", int'({hdr_valid, out_valid}), 0);
        inj_valid = 1'b0; hop_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hdr_valid == 1'b0 && out_valid == 1'b0, "R1", "valids after reset", int'({hdr_valid, out_valid}), 0);

        // directed: one-turn XY and YX
        walk(0, 0, 4, 4, 1'b0, 0);
        walk(0, 0, 4, 4, 1'b0, 1);
        walk(4, 3, 1, 0, 1'b0, 7);
        // source equals destination
        walk(2, 2, 2, 2, 1'b0, 0);
        // non-minimal XYX detour east of a north-bound path
        walk(1, 1, 1, 3, 1'b1, 4);
        // waypoint equals source (XYX column 1, then YXY row 1)
        walk(1, 1, 3, 0, 1'b1, 1);
        walk(1, 1, 3, 0, 1'b1, 6);
        // index wrap: 13 mod 10 = 3 -> XYX column 3; 19 -> YXY row 4
        walk(0, 2, 4, 0, 1'b1, 13);
        walk(3, 0, 0, 2, 1'b1, 19);
        // R7: leg 0 at destination but not at waypoint keeps moving
        walk(2, 2, 2, 2, 1'b1, 9);

        // R9: outputs hold while valid is low
        held_x = hdr_wp_x; held_y = hdr_wp_y; held_port = out_port;
        inj_src_x = 3'd4; inj_src_y = 3'd4; inj_two_turn = 1'b1; inj_rand = 16'd2;
        hop_cur_x = 3'd0; hop_dst_x = 3'd4; hop_class = 2'd0; hop_leg = 2'd1;
        @(negedge clk);
        @(negedge clk);
        chk(hdr_valid == 1'b0 && hdr_wp_x == held_x && hdr_wp_y == held_y, "R9", "header hold",
            int'(hdr_wp_x) * 8 + int'(hdr_wp_y), int'(held_x) * 8 + int'(held_y));
        chk(out_valid == 1'b0 && out_port == held_port, "R9", "port hold", int'(out_port), int'(held_port));

        for (int n = 0; n < 400; n++) begin
            walk(int'($urandom % BK), int'($urandom % BK), int'($urandom % BK), int'($urandom % BK),
                 bit'($urandom % 2), int'($urandom % 65536));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule